// File: doc/BRIEF.md
# Shared Word/Byte Bus Master

This block is the front end of one system-bus master port shared by three requesters: a bridge path that forwards accesses arriving from another bus, and two DMA channels. The downstream bus carries no byte-enable signals, so the only transfer sizes it can perform are a single byte and a full 32-bit word. The block grants one requester at a time by fixed priority and turns each granted request into one or more downstream transfers.

A word request goes out unchanged as one word transfer. A byte or halfword request from the bridge path becomes a run of byte transfers at ascending addresses. On writes, each byte is steered onto the lane its address selects. On reads, the returned bytes are packed into the requester's read data. The DMA channels may only issue word requests. A DMA request of any other size is rejected with an error and reaches the bus as nothing.

Each requester uses a valid/ready handshake. It holds valid and its request fields steady until ready pulses for one cycle, and it samples read data and error in that cycle.

Top module: `busm_share_split`

## Requirements
- R1: The downstream size output only ever carries byte (code 00) or word (code 10) while a transfer is requested. Halfword (01) and reserved (11) never appear there.
- R2: Requesters have fixed priority, index 0 (bridge path) over index 1 (DMA 0) over index 2 (DMA 1), and arbitration happens only when the block is idle. A granted request keeps the port until its response, even when a higher-priority requester raises valid meanwhile.
- R3: A word request (size 10) from any requester produces exactly one word transfer at the request address, with the request write data unchanged. For a read, the whole bus read word is returned.
- R4: A byte request (size 00) from the bridge path produces one byte transfer at the request address. The write data lane given by address bits [1:0] is driven on that lane and every other lane is zero. On a read, that lane of the bus data is returned and the other lanes read as zero.
- R5: A halfword request (size 01) from the bridge path produces two byte transfers, at the request address and then at the address plus one. On a read, each returned byte lands in the lane given by its own address bits [1:0], and the unused lanes are zero.
- R6: An unaligned halfword (address bits [1:0] = 11) is still split into bytes at the address and the address plus one. The second byte uses lane 0 of the write data and of the read data.
- R7: A DMA request (index 1 or 2) with a size other than word issues no transfer. The requester gets ready with error high and read data zero.
- R8: A request of reserved size 11 from any requester, the bridge path included, is rejected the same way as in R7.
- R9: Ready pulses for exactly one cycle, only for the granted requester, and only after the acknowledge of its last transfer. Error is low for every request that was issued on the bus.
- R10: Once a transfer request is raised, it stays raised with stable address, size, direction and write data until it is acknowledged.
- R11: While reset is asserted, no transfer is requested and no ready is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NREQ | Request valid per requester (0 bridge, 1 DMA 0, 2 DMA 1) |
| req_addr_i | input | NREQ x AW | Byte address per requester |
| req_size_i | input | NREQ x 2 | Size per requester: 00 byte, 01 halfword, 10 word, 11 reserved |
| req_we_i | input | NREQ | Write (1) or read (0) per requester |
| req_wdata_i | input | NREQ x DW | Lane-aligned write data per requester |
| req_ready_o | output | NREQ | One-cycle completion pulse per requester |
| req_err_o | output | NREQ | Rejected request, valid with ready |
| req_rdata_o | output | NREQ x DW | Read data, valid with ready |
| m_req_o | output | 1 | Downstream transfer request |
| m_addr_o | output | AW | Downstream address |
| m_size_o | output | 2 | Downstream size, 00 byte or 10 word |
| m_we_o | output | 1 | Downstream write |
| m_wdata_o | output | DW | Downstream write data |
| m_ack_i | input | 1 | Downstream acknowledge, completes the transfer at this clock edge |
| m_rdata_i | input | DW | Downstream read data, valid with acknowledge |

## Verification
Directed patterns cover the byte-lane corners. Bridge byte reads on all four lanes show whether other lanes are masked. Aligned and unaligned halfwords at address offsets 0, 1 and 3 reveal a wrong address increment or a missing wrap of the second byte to lane 0. Wrong-size DMA and reserved-size requests check that rejected requests stay off the bus. Simultaneous requests from all three requesters, and a bridge request that arrives while DMA 1 is being served, separate fixed priority from re-arbitration in the middle of a request. A long random mix of sizes, directions, offsets and requesters, served by a memory model with random acknowledge delay, is checked transfer by transfer against a queue of expected bus transfers and per-request read data.

// File: rtl/busm_pkg.sv
package busm_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_RESP
  } seq_state_e;
endpackage

// File: rtl/busm_arb.sv
module busm_arb #(
  parameter int NREQ = 3,
  parameter int IW   = 2
) (
  input  logic [NREQ-1:0] valid_i,
  output logic            any_o,
  output logic [IW-1:0]   sel_o
);
  assign any_o = |valid_i;

  // lowest index wins
  always_comb begin
    sel_o = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (valid_i[i]) sel_o = IW'(i);
    end
  end
endmodule

// File: rtl/busm_lane.sv
module busm_lane #(
  parameter int DW = 32,
  parameter int LW = 2
) (
  input  logic [LW-1:0] lane_i,
  input  logic          is_word_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic [DW-1:0] acc_i,
  output logic [DW-1:0] bus_wdata_o,
  output logic [DW-1:0] acc_o
);
  localparam int NB = DW / 8;

  always_comb begin
    bus_wdata_o = wdata_i;
    acc_o       = bus_rdata_i;
    if (!is_word_i) begin
      bus_wdata_o = '0;
      acc_o       = acc_i;
      for (int b = 0; b < NB; b++) begin
        if (LW'(b) == lane_i) begin
          bus_wdata_o[b*8 +: 8] = wdata_i[b*8 +: 8];
          acc_o[b*8 +: 8]       = bus_rdata_i[b*8 +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/busm_seq.sv
module busm_seq import busm_pkg::*; #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int IW         = 2,
  parameter int BRIDGE_IDX = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [IW-1:0] sel_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          m_ack_i,
  input  logic [DW-1:0] m_rdata_i,
  output logic [IW-1:0] owner_o,
  output logic          busy_o,
  output logic          resp_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o,
  output logic          m_req_o,
  output logic [AW-1:0] m_addr_o,
  output logic [1:0]    m_size_o,
  output logic          m_we_o,
  output logic [DW-1:0] m_wdata_o
);
  localparam int NB = DW / 8;
  localparam int LW = (NB > 1) ? $clog2(NB) : 1;

  seq_state_e    state_q;
  logic [IW-1:0] owner_q;
  logic [AW-1:0] base_q;
  logic [LW-1:0] cnt_q, last_q;
  logic          word_q, we_q, err_q;
  logic [DW-1:0] wdata_q, acc_q, acc_next;
  logic          bad_req;

  assign bad_req = (size_i == SZ_RSVD) ||
                   ((sel_i != IW'(BRIDGE_IDX)) && (size_i != SZ_WORD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      owner_q <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
      last_q  <= '0;
      word_q  <= 1'b0;
      we_q    <= 1'b0;
      err_q   <= 1'b0;
      wdata_q <= '0;
      acc_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          owner_q <= sel_i;
          base_q  <= addr_i;
          we_q    <= we_i;
          wdata_q <= wdata_i;
          acc_q   <= '0;
          cnt_q   <= '0;
          word_q  <= (size_i == SZ_WORD);
          last_q  <= (size_i == SZ_HALF) ? LW'(1) : '0;
          err_q   <= bad_req;
          state_q <= bad_req ? ST_RESP : ST_XFER;
        end
        ST_XFER: if (m_ack_i) begin
          acc_q <= acc_next;
          if (cnt_q == last_q) state_q <= ST_RESP;
          else                 cnt_q   <= cnt_q + LW'(1);
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign m_req_o  = (state_q == ST_XFER);
  assign m_addr_o = base_q + AW'(cnt_q);
  assign m_size_o = word_q ? SZ_WORD : SZ_BYTE;
  assign m_we_o   = we_q;

  busm_lane #(.DW(DW), .LW(LW)) u_lane (
    .lane_i      (m_addr_o[LW-1:0]),
    .is_word_i   (word_q),
    .wdata_i     (wdata_q),
    .bus_rdata_i (m_rdata_i),
    .acc_i       (acc_q),
    .bus_wdata_o (m_wdata_o),
    .acc_o       (acc_next)
  );

  assign owner_o = owner_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign resp_o  = (state_q == ST_RESP);
  assign err_o   = err_q;
  assign rdata_o = err_q ? '0 : acc_q;

  p_size_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_req_o |-> (m_size_o == SZ_BYTE || m_size_o == SZ_WORD));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_req_o && !m_ack_i |=> m_req_o && $stable(m_addr_o) && $stable(m_size_o)
                            && $stable(m_wdata_o) && $stable(m_we_o));

  p_ascend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_req_o && m_ack_i |=> resp_o || (m_req_o && m_addr_o == $past(m_addr_o) + AW'(1)));

  p_dma_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_req_o && owner_o != IW'(BRIDGE_IDX) |-> m_size_o == SZ_WORD);

  p_resp_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_o |=> !resp_o);
endmodule

// File: rtl/busm_share_split.sv
module busm_share_split import busm_pkg::*; #(
  parameter int NREQ       = 3,
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int BRIDGE_IDX = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NREQ-1:0]          req_valid_i,
  input  logic [NREQ-1:0][AW-1:0]  req_addr_i,
  input  logic [NREQ-1:0][1:0]     req_size_i,
  input  logic [NREQ-1:0]          req_we_i,
  input  logic [NREQ-1:0][DW-1:0]  req_wdata_i,
  output logic [NREQ-1:0]          req_ready_o,
  output logic [NREQ-1:0]          req_err_o,
  output logic [NREQ-1:0][DW-1:0]  req_rdata_o,
  output logic                     m_req_o,
  output logic [AW-1:0]            m_addr_o,
  output logic [1:0]               m_size_o,
  output logic                     m_we_o,
  output logic [DW-1:0]            m_wdata_o,
  input  logic                     m_ack_i,
  input  logic [DW-1:0]            m_rdata_i
);
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic          any, busy, resp, err;
  logic [IW-1:0] sel, owner;
  logic [DW-1:0] rdata;

  busm_arb #(.NREQ(NREQ), .IW(IW)) u_arb (
    .valid_i (req_valid_i),
    .any_o   (any),
    .sel_o   (sel)
  );

  busm_seq #(.AW(AW), .DW(DW), .IW(IW), .BRIDGE_IDX(BRIDGE_IDX)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (any),
    .sel_i     (sel),
    .addr_i    (req_addr_i[sel]),
    .size_i    (req_size_i[sel]),
    .we_i      (req_we_i[sel]),
    .wdata_i   (req_wdata_i[sel]),
    .m_ack_i   (m_ack_i),
    .m_rdata_i (m_rdata_i),
    .owner_o   (owner),
    .busy_o    (busy),
    .resp_o    (resp),
    .err_o     (err),
    .rdata_o   (rdata),
    .m_req_o   (m_req_o),
    .m_addr_o  (m_addr_o),
    .m_size_o  (m_size_o),
    .m_we_o    (m_we_o),
    .m_wdata_o (m_wdata_o)
  );

  for (genvar g = 0; g < NREQ; g++) begin : g_resp
    assign req_ready_o[g] = resp && (owner == IW'(g));
    assign req_err_o[g]   = req_ready_o[g] && err;
    assign req_rdata_o[g] = req_ready_o[g] ? rdata : '0;
  end

  p_ready_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o));

  p_bridge_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && req_valid_i[BRIDGE_IDX] |=> owner == IW'(BRIDGE_IDX));

  p_reset_quiet_r11: assert property (@(posedge clk_i)
    !rst_ni |-> !m_req_o && req_ready_o == '0);
endmodule

// File: tb/busm_share_split_tb_top.sv
module busm_share_split_tb_top;
  import busm_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NREQ = 3;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [NREQ-1:0]         valid = '0;
  logic [NREQ-1:0][AW-1:0] addr = '0;
  logic [NREQ-1:0][1:0]    size = '0;
  logic [NREQ-1:0]         we = '0;
  logic [NREQ-1:0][DW-1:0] wdata = '0;
  logic [NREQ-1:0]         ready, err;
  logic [NREQ-1:0][DW-1:0] rdata;
  logic          m_req, m_we, m_ack;
  logic [AW-1:0] m_addr;
  logic [1:0]    m_size;
  logic [DW-1:0] m_wdata, m_rdata;

  busm_share_split dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(valid), .req_addr_i(addr), .req_size_i(size),
    .req_we_i(we), .req_wdata_i(wdata),
    .req_ready_o(ready), .req_err_o(err), .req_rdata_o(rdata),
    .m_req_o(m_req), .m_addr_o(m_addr), .m_size_o(m_size),
    .m_we_o(m_we), .m_wdata_o(m_wdata), .m_ack_i(m_ack), .m_rdata_i(m_rdata)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] mem [256];
  logic [66:0] exp_q [$];
  string tag_q [$];

  task automatic check(bit ok, string tag, string what, logic [79:0] act, logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(logic [7:0] a);
    logic [7:0] b;
    b = a & 8'hfc;
    return {mem[b + 8'd3], mem[b + 8'd2], mem[b + 8'd1], mem[b]};
  endfunction

  // slave model and transfer monitor
  initial begin
    bit waiting = 0;
    logic [66:0] prev = '0;
    m_ack = 1'b0;
    m_rdata = '0;
    forever begin
      @(negedge clk);
      if (m_ack) begin
        m_ack = 1'b0;
        waiting = 0;
      end else if (rst_n && m_req) begin
        logic [66:0] cur;
        cur = {m_addr, m_size, m_we, m_wdata};
        if (waiting) check(cur == prev, "R10", "held transfer", 80'(cur), 80'(prev));
        if ($urandom_range(0, 2) != 0) begin
          logic [66:0] got;
          got = {m_addr, m_size, m_we, m_we ? m_wdata : 32'h0};
          check(m_size == SZ_BYTE || m_size == SZ_WORD, "R1", "bus size", 80'(m_size), 80'(SZ_BYTE));
          if (exp_q.size() == 0) begin
            check(0, "R3", "unexpected transfer", 80'(got), 80'(0));
          end else begin
            logic [66:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(got == e, t, "transfer", 80'(got), 80'(e));
          end
          m_rdata = mem_word(m_addr[7:0]);
          if (m_we) begin
            if (m_size == SZ_WORD) begin
              for (int k = 0; k < 4; k++) mem[(m_addr[7:0] & 8'hfc) + 8'(k)] = m_wdata[8*k +: 8];
            end else begin
              mem[m_addr[7:0]] = m_wdata[8*m_addr[1:0] +: 8];
            end
          end
          m_ack = 1'b1;
          waiting = 0;
        end else begin
          waiting = 1;
          prev = cur;
        end
      end else begin
        waiting = 0;
      end
    end
  end

  task automatic do_req(int r, logic [31:0] a, logic [1:0] sz, logic w, logic [31:0] wd, bit push);
    bit bad;
    string tg;
    logic [31:0] exp_rd;
    bad = (sz == SZ_RSVD) || (r != 0 && sz != SZ_WORD);
    if (sz == SZ_RSVD) tg = "R8";
    else if (bad) tg = "R7";
    else if (sz == SZ_WORD) tg = "R3";
    else if (sz == SZ_BYTE) tg = "R4";
    else if (a[1:0] == 2'b11) tg = "R6";
    else tg = "R5";
    exp_rd = '0;
    if (!bad) begin
      if (sz == SZ_WORD) begin
        if (push) begin exp_q.push_back({a, SZ_WORD, w, w ? wd : 32'h0}); tag_q.push_back(tg); end
        exp_rd = mem_word(a[7:0]);
      end else begin
        for (int k = 0; k < ((sz == SZ_HALF) ? 2 : 1); k++) begin
          logic [31:0] aa;
          aa = a + 32'(k);
          if (push) begin
            exp_q.push_back({aa, SZ_BYTE, w, w ? (wd & (32'hff << (8 * aa[1:0]))) : 32'h0});
            tag_q.push_back(tg);
          end
          exp_rd[8*aa[1:0] +: 8] = mem[aa[7:0]];
        end
      end
    end
    @(negedge clk);
    valid[r] = 1'b1; addr[r] = a; size[r] = sz; we[r] = w; wdata[r] = wd;
    do @(negedge clk); while (!ready[r]);
    check(err[r] == bad, bad ? tg : "R9", "error flag", 80'(err[r]), 80'(bad));
    if (!w || bad) check(rdata[r] == exp_rd, tg, "read data", 80'(rdata[r]), 80'(exp_rd));
    check((ready & ~(3'b1 << r)) == '0, "R9", "ready only to owner", 80'(ready), 80'(3'b1 << r));
    valid[r] = 1'b0;
    @(negedge clk);
    check(!ready[r], "R9", "ready pulse width", 80'(ready[r]), 80'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired R9 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    check(!m_req && ready == '0, "R11", "quiet in reset", 80'({m_req, ready}), 80'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 word write and read
    do_req(1, 32'h1000_0010, SZ_WORD, 1'b1, 32'hdead_beef, 1);
    do_req(1, 32'h1000_0010, SZ_WORD, 1'b0, 32'h0, 1);
    do_req(0, 32'h1000_0020, SZ_WORD, 1'b0, 32'h0, 1);
    // R4 byte reads on every lane, byte write
    for (int l = 0; l < 4; l++) do_req(0, 32'h1000_0040 + 32'(l), SZ_BYTE, 1'b0, 32'h0, 1);
    do_req(0, 32'h1000_0042, SZ_BYTE, 1'b1, 32'h11223344, 1);
    do_req(0, 32'h1000_0040, SZ_WORD, 1'b0, 32'h0, 1);
    // R5 aligned and odd halfwords
    do_req(0, 32'h1000_0050, SZ_HALF, 1'b1, 32'hcafe_f00d, 1);
    do_req(0, 32'h1000_0050, SZ_HALF, 1'b0, 32'h0, 1);
    do_req(0, 32'h1000_0051, SZ_HALF, 1'b0, 32'h0, 1);
    // R6 halfword crossing a word boundary
    do_req(0, 32'h1000_0063, SZ_HALF, 1'b1, 32'h5a00_00a5, 1);
    do_req(0, 32'h1000_0063, SZ_HALF, 1'b0, 32'h0, 1);
    // R7 and R8 rejected sizes
    do_req(2, 32'h1000_0070, SZ_HALF, 1'b1, 32'h1234_5678, 1);
    do_req(1, 32'h1000_0070, SZ_BYTE, 1'b0, 32'h0, 1);
    do_req(0, 32'h1000_0070, SZ_RSVD, 1'b0, 32'h0, 1);
    do_req(0, 32'h1000_0070, SZ_WORD, 1'b0, 32'h0, 1);

    // R2 simultaneous requests resolve by priority
    exp_q.push_back({32'h1000_0080, SZ_WORD, 1'b1, 32'ha0a0_a0a0}); tag_q.push_back("R2");
    exp_q.push_back({32'h1000_0084, SZ_WORD, 1'b1, 32'hb1b1_b1b1}); tag_q.push_back("R2");
    exp_q.push_back({32'h1000_0088, SZ_WORD, 1'b1, 32'hc2c2_c2c2}); tag_q.push_back("R2");
    fork
      do_req(2, 32'h1000_0088, SZ_WORD, 1'b1, 32'hc2c2_c2c2, 0);
      do_req(1, 32'h1000_0084, SZ_WORD, 1'b1, 32'hb1b1_b1b1, 0);
      do_req(0, 32'h1000_0080, SZ_WORD, 1'b1, 32'ha0a0_a0a0, 0);
    join

    // R2 grant held against a later higher-priority request
    exp_q.push_back({32'h1000_0090, SZ_WORD, 1'b1, 32'h0102_0304}); tag_q.push_back("R2");
    exp_q.push_back({32'h1000_0095, SZ_BYTE, 1'b1, 32'h0000_ee00}); tag_q.push_back("R2");
    fork
      do_req(2, 32'h1000_0090, SZ_WORD, 1'b1, 32'h0102_0304, 0);
      begin
        repeat (2) @(negedge clk);
        do_req(0, 32'h1000_0095, SZ_BYTE, 1'b1, 32'h00ff_ee00, 0);
      end
    join

    // random mix of requesters, sizes, offsets and directions
    for (int n = 0; n < 120; n++) begin
      do_req($urandom_range(0, 2), 32'h1000_0000 | 32'($urandom_range(0, 255)),
             2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), $urandom, 1);
    end

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3", "all expected transfers seen", 80'(exp_q.size()), 80'(0));
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule